// File: doc/BRIEF.md
# Bipolar Half-Pulse Validity Classifier

This block watches two sampled comparator flags on a differential receive line. One flag says the line is above a positive threshold and the other says it is below a negative one. A transmitted symbol is a half-pulse of one polarity followed by an inversion to the opposite polarity. The block times the first half-pulse and the wait until the inversion. It accepts the symbol only when both timings fall inside the limits. It then reports the symbol on a one-cycle strobe.

Every accepted symbol carries two tags. The first is its polarity: +1 when it starts positive, -1 when it starts negative. The second is its class: long for chip-select framing, short for data. A half-pulse long enough for the long timer, with its inversion inside the long window, is long. One that meets only the short limits is short. Anything else is dropped silently. All widths are counted in clock cycles and set by parameters. The two inputs are assumed to be already synchronous to `clk_i`.

Timing terms used below. The width W is the number of consecutive cycles of the first polarity, counted from the first such cycle. The elapsed count E is the number of cycles from that first cycle up to, but not including, the first cycle of opposite polarity. Cycles between the first half and the inversion must be neutral, with neither flag set.

Top module: `hp_classifier`

## Requirements
- R1: While `rst_ni` is low, and after it rises with neutral inputs, `sym_valid_o` is 0. A reset in the middle of a half-pulse discards it, and the next well-formed symbol decodes normally.
- R2: A symbol with W >= LONG_MIN_HP and E <= LONG_MAX_INV is reported with `sym_long_o` = 1. With `above_i` high first, `sym_pos_o` = 1.
- R3: A symbol with W >= SHORT_MIN_HP and E <= SHORT_MAX_INV that fails the long test is reported with `sym_long_o` = 0.
- R4: A symbol starting with `below_i` high follows the same timing rules and is reported with `sym_pos_o` = 0.
- R5: A symbol with W < SHORT_MIN_HP produces no strobe.
- R6: A symbol that meets neither the long nor the short pair of limits produces no strobe. E = LONG_MAX_INV with W >= LONG_MIN_HP is still accepted as long.
- R7: Both flags high during a half-pulse or its neutral gap reject the symbol. Both flags high while idle start nothing.
- R8: `sym_valid_o` goes high for exactly one cycle, OUT_DELAY clock edges after (and counting) the edge that samples the first inversion cycle. Consecutive symbols each give their own strobe.
- R9: After an accepted inversion, no new symbol starts until both flags are low. Opposite or repeated polarity before that gives no strobe.
- R10: A return to the first polarity after a neutral gap rejects the symbol.
- R11: A non-inverting cycle seen while the elapsed count already equals LONG_MAX_INV rejects the symbol and returns the block to idle. So a polarity held past that limit gives no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| above_i | input | 1 | Line above the positive threshold |
| below_i | input | 1 | Line below the negative threshold |
| sym_valid_o | output | 1 | One-cycle strobe for an accepted symbol |
| sym_long_o | output | 1 | 1 = long (chip-select) symbol, 0 = short (data) symbol |
| sym_pos_o | output | 1 | 1 = +1 symbol (positive first), 0 = -1 symbol |

## Verification
The cases hardest to reach from the pins sit exactly on the timer limits. One is an inversion arriving on the very cycle the elapsed count reaches LONG_MAX_INV. Another is a first polarity held one cycle too long. A third is a half-pulse of width 7, which is too wide for the short window yet too narrow for the long minimum. The stimulus builds each of these from explicit counts of polarity, gap and inversion cycles. It uses long neutral tails so that every rejected fragment settles back to idle before the next case. It also drives back-to-back symbols and a reset in mid-pulse, so that delayed strobes and state recovery are exercised against the cycle-accurate model.

// File: rtl/hp_pkg.sv
`timescale 1ns/1ps
package hp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HALF = 2'd1,
    ST_GAP  = 2'd2,
    ST_TAIL = 2'd3
  } hp_state_e;

  // Returns {ok, long}. Long takes priority; short is the fallback.
  function automatic logic [1:0] hp_classify(input int width, input int elapsed,
                                             input int smin, input int smax,
                                             input int lmin, input int lmax);
    logic is_long;
    logic is_ok;
    is_long = (width >= lmin) && (elapsed <= lmax);
    is_ok   = is_long || ((width >= smin) && (elapsed <= smax));
    return {is_ok, is_long};
  endfunction

endpackage

// File: rtl/hp_timer.sv
`timescale 1ns/1ps
module hp_timer #(
  parameter int CW    = 5,
  parameter int LIMIT = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          inc_i,
  output logic [CW-1:0] count_o,
  output logic          at_limit_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      count_o <= '0;
    end else if (load_i) begin
      count_o <= CW'(1);
    end else if (inc_i) begin
      count_o <= count_o + 1'b1;
    end
  end

  assign at_limit_o = (count_o == CW'(LIMIT));

endmodule

// File: rtl/hp_delay.sv
`timescale 1ns/1ps
module hp_delay #(
  parameter int DEPTH = 2,
  parameter int W     = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);

  logic [DEPTH-1:0] v_q;
  logic [W-1:0]     d_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      v_q[0] <= 1'b0;
      d_q[0] <= '0;
    end else begin
      v_q[0] <= in_valid_i;
      d_q[0] <= in_data_i;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        v_q[g] <= 1'b0;
        d_q[g] <= '0;
      end else begin
        v_q[g] <= v_q[g-1];
        d_q[g] <= d_q[g-1];
      end
    end
  end

  assign out_valid_o = v_q[DEPTH-1];
  assign out_data_o  = d_q[DEPTH-1];

endmodule

// File: rtl/hp_classifier.sv
`timescale 1ns/1ps
module hp_classifier
  import hp_pkg::*;
#(
  parameter int SHORT_MIN_HP  = 3,
  parameter int SHORT_MAX_INV = 6,
  parameter int LONG_MIN_HP   = 8,
  parameter int LONG_MAX_INV  = 14,
  parameter int OUT_DELAY     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_i,
  input  logic below_i,
  output logic sym_valid_o,
  output logic sym_long_o,
  output logic sym_pos_o
);

  localparam int CW = $clog2(LONG_MAX_INV + 1) + 1;

  hp_state_e     state_q, state_d;
  logic          pol_q;
  logic [CW-1:0] width_q;
  logic [CW-1:0] elapsed_w;
  logic          at_limit_w;

  // Named events on the input levels
  logic lvl_zero_w, lvl_both_w, lvl_pos_w, lvl_neg_w, lvl_same_w, lvl_opp_w;
  assign lvl_zero_w = !above_i && !below_i;
  assign lvl_both_w = above_i && below_i;
  assign lvl_pos_w  = above_i && !below_i;
  assign lvl_neg_w  = below_i && !above_i;
  assign lvl_same_w = pol_q ? lvl_pos_w : lvl_neg_w;
  assign lvl_opp_w  = pol_q ? lvl_neg_w : lvl_pos_w;

  // Named events on the pulse progress
  logic          in_pulse_w, start_w, inv_w, hold_w, timeout_w;
  logic          accept_w, accept_long_w;
  logic [CW-1:0] width_now_w;
  logic [1:0]    class_w;

  assign in_pulse_w  = (state_q == ST_HALF) || (state_q == ST_GAP);
  assign start_w     = (state_q == ST_IDLE) && (lvl_pos_w || lvl_neg_w);
  assign inv_w       = in_pulse_w && lvl_opp_w;
  assign hold_w      = in_pulse_w &&
                       (lvl_zero_w || ((state_q == ST_HALF) && lvl_same_w));
  assign timeout_w   = hold_w && at_limit_w;
  assign width_now_w = (state_q == ST_HALF) ? elapsed_w : width_q;
  assign class_w     = hp_classify(int'(width_now_w), int'(elapsed_w),
                                   SHORT_MIN_HP, SHORT_MAX_INV,
                                   LONG_MIN_HP, LONG_MAX_INV);
  assign accept_w      = inv_w && class_w[1];
  assign accept_long_w = accept_w && class_w[0];

  hp_timer #(.CW(CW), .LIMIT(LONG_MAX_INV)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_w),
    .inc_i      (hold_w && !at_limit_w),
    .count_o    (elapsed_w),
    .at_limit_o (at_limit_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_w) state_d = ST_HALF;
      ST_HALF: begin
        if (inv_w)                         state_d = accept_w ? ST_TAIL : ST_IDLE;
        else if (timeout_w || lvl_both_w)  state_d = ST_IDLE;
        else if (lvl_zero_w)               state_d = ST_GAP;
      end
      ST_GAP: begin
        if (inv_w)                         state_d = accept_w ? ST_TAIL : ST_IDLE;
        else if (timeout_w || !lvl_zero_w) state_d = ST_IDLE;
      end
      ST_TAIL: if (lvl_zero_w) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pol_q   <= 1'b0;
      width_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_w) pol_q <= lvl_pos_w;
      if ((state_q == ST_HALF) && lvl_zero_w) width_q <= elapsed_w;
    end
  end

  logic [1:0] out_data_w;

  hp_delay #(.DEPTH(OUT_DELAY), .W(2)) u_delay (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (accept_w),
    .in_data_i   ({accept_long_w, pol_q}),
    .out_valid_o (sym_valid_o),
    .out_data_o  (out_data_w)
  );

  assign sym_long_o = out_data_w[1];
  assign sym_pos_o  = out_data_w[0];

endmodule

// File: rtl/hp_classifier_chk.sv
`timescale 1ns/1ps
module hp_classifier_chk
  import hp_pkg::*;
#(
  parameter int CW            = 5,
  parameter int SHORT_MIN_HP  = 3,
  parameter int SHORT_MAX_INV = 6,
  parameter int LONG_MIN_HP   = 8,
  parameter int LONG_MAX_INV  = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input hp_state_e     state_q,
  input logic [CW-1:0] elapsed_w,
  input logic [CW-1:0] width_now_w,
  input logic          accept_w,
  input logic          accept_long_w,
  input logic          lvl_both_w,
  input logic          lvl_zero_w,
  input logic          sym_valid_o
);

  p_long_limits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_long_w |-> (int'(width_now_w) >= LONG_MIN_HP) && (int'(elapsed_w) <= LONG_MAX_INV));

  p_min_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |-> int'(width_now_w) >= SHORT_MIN_HP);

  p_short_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_w && !accept_long_w) |-> int'(elapsed_w) <= SHORT_MAX_INV);

  p_both_rejects_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((state_q == ST_HALF) || (state_q == ST_GAP)) && lvl_both_w) |=> (state_q == ST_IDLE));

  p_single_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |=> !sym_valid_o);

  p_tail_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_TAIL) && !lvl_zero_w) |=> (state_q == ST_TAIL));

  p_timer_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(elapsed_w) <= LONG_MAX_INV);

endmodule

bind hp_classifier hp_classifier_chk #(
  .CW            (CW),
  .SHORT_MIN_HP  (SHORT_MIN_HP),
  .SHORT_MAX_INV (SHORT_MAX_INV),
  .LONG_MIN_HP   (LONG_MIN_HP),
  .LONG_MAX_INV  (LONG_MAX_INV)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .state_q       (state_q),
  .elapsed_w     (elapsed_w),
  .width_now_w   (width_now_w),
  .accept_w      (accept_w),
  .accept_long_w (accept_long_w),
  .lvl_both_w    (lvl_both_w),
  .lvl_zero_w    (lvl_zero_w),
  .sym_valid_o   (sym_valid_o)
);

// File: tb/sim_hp_classifier.sv
`timescale 1ns/1ps
module sim_hp_classifier;

  localparam int SMIN = 3;
  localparam int SMAX = 6;
  localparam int LMIN = 8;
  localparam int LMAX = 14;
  localparam int DEL  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above = 1'b0;
  logic below = 1'b0;
  logic sym_valid, sym_long, sym_pos;

  always #2.5 clk = ~clk;

  hp_classifier #(
    .SHORT_MIN_HP(SMIN), .SHORT_MAX_INV(SMAX),
    .LONG_MIN_HP(LMIN), .LONG_MAX_INV(LMAX), .OUT_DELAY(DEL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .above_i(above), .below_i(below),
    .sym_valid_o(sym_valid), .sym_long_o(sym_long), .sym_pos_o(sym_pos)
  );

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  // Reference model state
  int m_st = 0;   // 0 idle, 1 first half, 2 neutral gap, 3 after inversion
  int m_pol = 0;
  int m_cnt = 0;
  int m_w = 0;
  int step = 0;
  int q_due[$];
  int q_long[$];
  int q_pos[$];

  int strobes = 0;
  int last_long = 0;
  int last_pos = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(input bit a, input bit b);
    bit z, pos, neg, same, opp;
    int w;
    z = !a && !b;
    pos = a && !b;
    neg = b && !a;
    same = (m_pol != 0) ? pos : neg;
    opp  = (m_pol != 0) ? neg : pos;
    case (m_st)
      0: if (pos || neg) begin m_st = 1; m_pol = pos; m_cnt = 1; end
      1, 2: begin
        if (opp) begin
          w = (m_st == 1) ? m_cnt : m_w;
          if (w >= LMIN && m_cnt <= LMAX) begin
            q_due.push_back(step + DEL); q_long.push_back(1); q_pos.push_back(m_pol); m_st = 3;
          end else if (w >= SMIN && m_cnt <= SMAX) begin
            q_due.push_back(step + DEL); q_long.push_back(0); q_pos.push_back(m_pol); m_st = 3;
          end else m_st = 0;
        end else if (z || (m_st == 1 && same)) begin
          if (m_cnt == LMAX) m_st = 0;
          else begin
            if (m_st == 1 && z) begin m_w = m_cnt; m_st = 2; end
            m_cnt++;
          end
        end else m_st = 0;
      end
      3: if (z) m_st = 0;
      default: m_st = 0;
    endcase
  endtask

  // Compare on the falling edge, then drive the next input and step the model
  task automatic drive(input bit a, input bit b);
    bit ev;
    @(negedge clk);
    ev = (q_due.size() > 0) && (q_due[0] == step);
    check(sym_valid == ev, cur_req, "valid", int'(sym_valid), int'(ev));
    if (ev) begin
      check(int'(sym_long) == q_long[0], cur_req, "long", int'(sym_long), q_long[0]);
      check(int'(sym_pos) == q_pos[0], cur_req, "pos", int'(sym_pos), q_pos[0]);
      void'(q_due.pop_front()); void'(q_long.pop_front()); void'(q_pos.pop_front());
    end
    if (sym_valid) begin strobes++; last_long = sym_long; last_pos = sym_pos; end
    above = a;
    below = b;
    model_step(a, b);
    step++;
  endtask

  task automatic hold(input bit a, input bit b, input int n);
    for (int i = 0; i < n; i++) drive(a, b);
  endtask

  // first polarity (1 = above), width, neutral gap, inversion length, then a long settle
  task automatic pulse(input bit p, input int w, input int gap, input int inv);
    hold(p, !p, w);
    hold(1'b0, 1'b0, gap);
    hold(!p, p, inv);
    hold(1'b0, 1'b0, 20);
  endtask

  task automatic scen(input string req);
    cur_req = req;
    strobes = 0;
  endtask

  task automatic scen_end(input int n, input int lg, input int ps);
    check(strobes == n, cur_req, "strobe count", strobes, n);
    if (n > 0) begin
      check(last_long == lg, cur_req, "final long", last_long, lg);
      check(last_pos == ps, cur_req, "final pos", last_pos, ps);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(sym_valid == 1'b0, "R1", "valid in reset", int'(sym_valid), 0);
    rst_n = 1'b1;
    scen("R1"); hold(1'b0, 1'b0, 4); scen_end(0, 0, 0);

    scen("R2"); pulse(1'b1, 10, 0, 4); scen_end(1, 1, 1);
    scen("R3"); pulse(1'b1, 4, 1, 3); scen_end(1, 0, 1);
    scen("R4"); pulse(1'b0, 8, 0, 3); scen_end(1, 1, 0);
    scen("R4"); pulse(1'b0, 3, 0, 3); scen_end(1, 0, 0);
    scen("R5"); pulse(1'b1, 2, 0, 3); scen_end(0, 0, 0);
    scen("R6"); pulse(1'b1, 4, 3, 3); scen_end(0, 0, 0);
    scen("R6"); pulse(1'b1, 7, 0, 3); scen_end(0, 0, 0);
    scen("R6"); pulse(1'b1, 8, 6, 3); scen_end(1, 1, 1);
    scen("R11"); pulse(1'b1, 8, 7, 3); scen_end(0, 0, 0);

    // R7: both flags mid-pulse, and both flags while idle
    scen("R7");
    hold(1'b1, 1'b0, 4); hold(1'b1, 1'b1, 1); hold(1'b0, 1'b1, 3); hold(1'b0, 1'b0, 20);
    scen_end(0, 0, 0);
    scen("R7");
    hold(1'b1, 1'b0, 4); hold(1'b0, 1'b0, 1); hold(1'b1, 1'b1, 1); hold(1'b0, 1'b1, 3);
    hold(1'b0, 1'b0, 20);
    scen_end(0, 0, 0);
    scen("R7"); hold(1'b1, 1'b1, 3); pulse(1'b1, 4, 0, 3); scen_end(1, 0, 1);

    // R8: back-to-back symbols
    scen("R8");
    hold(1'b1, 1'b0, 3); hold(1'b0, 1'b1, 1); hold(1'b0, 1'b0, 1);
    hold(1'b0, 1'b1, 3); hold(1'b1, 1'b0, 1); hold(1'b0, 1'b0, 20);
    scen_end(2, 0, 0);

    // R9: long second half and a polarity flip before returning to neutral
    scen("R9"); pulse(1'b1, 10, 0, 25); scen_end(1, 1, 1);
    scen("R9");
    hold(1'b1, 1'b0, 10); hold(1'b0, 1'b1, 3); hold(1'b1, 1'b0, 5); hold(1'b0, 1'b0, 20);
    scen_end(1, 1, 1);

    // R10: same polarity returns after a gap
    scen("R10");
    hold(1'b1, 1'b0, 4); hold(1'b0, 1'b0, 1); hold(1'b1, 1'b0, 2); hold(1'b0, 1'b1, 3);
    hold(1'b0, 1'b0, 20);
    scen_end(0, 0, 0);

    // R11: held polarity, plus both sides of the limit
    scen("R11"); hold(1'b1, 1'b0, 30); hold(1'b0, 1'b0, 20); scen_end(0, 0, 0);
    scen("R11"); pulse(1'b0, 14, 0, 3); scen_end(1, 1, 0);
    scen("R11"); pulse(1'b0, 15, 0, 3); scen_end(0, 0, 0);

    // R1: reset in the middle of a half-pulse
    scen("R1");
    hold(1'b1, 1'b0, 5);
    @(negedge clk);
    rst_n = 1'b0; above = 1'b0; below = 1'b0;
    m_st = 0; q_due.delete(); q_long.delete(); q_pos.delete();
    @(negedge clk);
    check(sym_valid == 1'b0, "R1", "valid in mid reset", int'(sym_valid), 0);
    rst_n = 1'b1;
    pulse(1'b0, 3, 0, 2);
    scen_end(1, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule